// File: doc/BRIEF.md
# DMA Channel Address/Count Registers with Autoload

This block keeps the transfer address and remaining-count registers for a four-channel DMA engine. Each time the engine reports a finished transfer on a channel, the block moves that channel's address up by one and its count down by one. It flags terminal count in the same cycle as the last transfer of a block. A shared stop option can switch a channel off automatically once its block ends.

In autoload mode, channel 2 is the only channel that moves data, and channel 3 holds the parameters of the next block. Writing channel 2 in this mode also writes the same value into channel 3, which gives repeat-block operation. Writing channel 3 afterwards with different values gives block chaining. When channel 2 reaches terminal count, an update cycle copies channel 3 into channel 2 on the same clock edge and raises an update flag. The flag clears when the first transfer of the next block completes.

Top module: `dma_al_core`

## Requirements
- R1: A transfer pulse (`xfer_done`) on a channel whose enable bit is 1 adds 1 to that channel's address and subtracts 1 from its count at the next clock edge. A pulse on a channel whose enable bit is 0 changes nothing.
- R2: `tc` is 1 during the cycle of an accepted transfer whose count reads 0. The count then wraps to all ones (2^CNT_W-1), unless an update cycle reloads it.
- R3: With `tc_stop` = 1, a channel's enable bit drops to 0 on the clock edge that ends its terminal-count transfer. The other enable bits are unchanged.
- R4: With `tc_stop` = 0, terminal count leaves every enable bit unchanged.
- R5: With `autoload` = 1, channel 2 keeps its enable at terminal count even when `tc_stop` = 1. Channel 2 transfers proceed whatever channel 3's enable is, and transfer pulses for channel 3 are ignored.
- R6: With `autoload` = 1, a register write to channel 2 also writes the same register of channel 3.
- R7: With `autoload` = 1, on the clock edge that ends channel 2's terminal-count transfer, channel 2's address and count take channel 3's values and `upd_flag` goes to 1.
- R8: `upd_flag` returns to 0 at the end of the first accepted channel 2 transfer after an update that is not itself a terminal-count transfer.
- R9: A write to channel 3 that arrives in the same clock as an update cycle is discarded. Channel 2 receives channel 3's previous contents.
- R10: After reset, all addresses, counts, enable bits, `upd_flag` and `tc` are 0.
- R11: A register write to a channel overrides a same-clock transfer advance of that register. `wr_sel` = 0 selects the address and 1 selects the count. The count takes the low CNT_W bits of `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel written |
| wr_sel | input | 1 | 0 = address register, 1 = count register |
| wr_data | input | ADDR_W | Write data |
| en_wr | input | 1 | Load the enable bits from `en_wdata` |
| en_wdata | input | NUM_CH | New enable bits, bit i for channel i |
| tc_stop | input | 1 | Disable a channel at its terminal count (shared by all channels) |
| autoload | input | 1 | Channel 3 reloads channel 2 |
| xfer_done | input | 1 | One transfer finished on `xfer_ch` |
| xfer_ch | input | 2 | Channel of the transfer; also selects `cur_addr`/`cur_cnt` |
| cur_addr | output | ADDR_W | Address register of `xfer_ch` |
| cur_cnt | output | CNT_W | Count register of `xfer_ch` |
| tc | output | 1 | Terminal count, during the last transfer of a block |
| ch_en | output | NUM_CH | Current enable bits |
| upd_flag | output | 1 | Status: an update cycle has occurred |

## Verification
The bench builds the block with ADDR_W = 16 and CNT_W = 6. The narrow count makes the wrap value after terminal count (0x3F) a short, distinctive constant. The full 16-bit address shows any stray carry or reload. Counts of 0, 1 and 2 reach terminal count within a few transfers. This lets the bench cover, in directed steps, the stop and no-stop cases, repeat-block and chaining reloads, and a write that collides with an update.

// File: rtl/dma_al_pkg.sv
// Shared constants for the DMA address/count block.
// Assumes four channels; autoload copies AL_SRC into AL_DST.
package dma_al_pkg;
    localparam int AL_SRC   = 3;    // reload source channel
    localparam int AL_DST   = 2;    // channel that transfers in autoload
    localparam bit SEL_ADDR = 1'b0; // wr_sel value for the address register
    localparam bit SEL_CNT  = 1'b1; // wr_sel value for the count register
endpackage

// File: rtl/dma_al_chreg.sv
// One channel's address and count registers.
// Priority: reload > register write > transfer advance.
// Assumes ld_data is at least CNT_W bits wide.
module dma_al_chreg #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic              adv,
    input  logic              reload,
    input  logic [ADDR_W-1:0] rl_addr,
    input  logic [CNT_W-1:0]  rl_cnt,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q
);
    // Address/count update with reload, write and advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (reload) begin
            addr_q <= rl_addr;
            cnt_q  <= rl_cnt;
        end else begin
            if (ld_addr)  addr_q <= ld_data;
            else if (adv) addr_q <= addr_q + 1'b1;
            if (ld_cnt)   cnt_q  <= ld_data[CNT_W-1:0];
            else if (adv) cnt_q  <= cnt_q - 1'b1;
        end
    end

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reload && !ld_addr && !ld_cnt) |=>
        (addr_q == ADDR_W'($past(addr_q) + 1'b1)) && (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R1
    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (addr_q == $past(rl_addr)) && (cnt_q == $past(rl_cnt))); // R7
endmodule

// File: rtl/dma_al_ctrl.sv
// Transfer acceptance, terminal count, enable bits and update flag.
// Assumes sel_cnt is the count register of xfer_ch in the same cycle.
module dma_al_ctrl
    import dma_al_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 14,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_done,
    input  logic [CH_W-1:0]   xfer_ch,
    input  logic [CNT_W-1:0]  sel_cnt,
    input  logic              en_wr,
    input  logic [NUM_CH-1:0] en_wdata,
    input  logic              tc_stop,
    input  logic              autoload,
    output logic [NUM_CH-1:0] adv,
    output logic              tc,
    output logic              reload,
    output logic [NUM_CH-1:0] en_q,
    output logic              upd_q
);
    logic              al_src, al_dst, accept;
    logic [NUM_CH-1:0] en_nxt;

    // Decode which transfers count and whether this one ends a block.
    always_comb begin
        al_src = autoload && (xfer_ch == CH_W'(AL_SRC));
        al_dst = autoload && (xfer_ch == CH_W'(AL_DST));
        accept = xfer_done && en_q[xfer_ch] && !al_src;
        tc     = accept && (sel_cnt == '0);
        reload = tc && al_dst;
    end

    // One-hot advance strobe per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_adv
        assign adv[i] = accept && (xfer_ch == CH_W'(i));
    end

    // Next enables: software load, then auto-disable at terminal count.
    always_comb begin
        en_nxt = en_wr ? en_wdata : en_q;
        if (tc && tc_stop && !al_dst) en_nxt[xfer_ch] = 1'b0;
    end

    // Enable and update-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            upd_q <= 1'b0;
        end else begin
            en_q <= en_nxt;
            if (reload)                  upd_q <= 1'b1;
            else if (accept && al_dst)   upd_q <= 1'b0;
        end
    end

    AST_TC_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && tc_stop && !al_dst) |=> !en_q[$past(xfer_ch)]); // R3
    AST_TC_KEEP_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !tc_stop && !en_wr) |=> (en_q == $past(en_q))); // R4
    AST_AL_KEEP_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !en_wr) |=> en_q[AL_DST]); // R5
    AST_UPD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> upd_q); // R7
    AST_UPD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && autoload && en_q[AL_DST] && xfer_ch == CH_W'(AL_DST) && sel_cnt != '0) |=> !upd_q); // R8
endmodule

// File: rtl/dma_al_core.sv
// Top: four channel register sets plus control. Decodes register writes,
// duplicates channel 2 writes into channel 3 in autoload mode and drops a
// channel 3 write that collides with an update cycle.
// Assumes NUM_CH covers AL_SRC and AL_DST and ADDR_W >= CNT_W.
module dma_al_core
    import dma_al_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              en_wr,
    input  logic [NUM_CH-1:0] en_wdata,
    input  logic              tc_stop,
    input  logic              autoload,
    input  logic              xfer_done,
    input  logic [CH_W-1:0]   xfer_ch,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              tc,
    output logic [NUM_CH-1:0] ch_en,
    output logic              upd_flag
);
    logic [ADDR_W-1:0] addr_a [NUM_CH];
    logic [CNT_W-1:0]  cnt_a  [NUM_CH];
    logic [NUM_CH-1:0] adv;
    logic              reload;

    assign cur_addr = addr_a[xfer_ch];
    assign cur_cnt  = cnt_a[xfer_ch];

    dma_al_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_ch(xfer_ch),
        .sel_cnt(cnt_a[xfer_ch]), .en_wr(en_wr), .en_wdata(en_wdata),
        .tc_stop(tc_stop), .autoload(autoload), .adv(adv), .tc(tc),
        .reload(reload), .en_q(ch_en), .upd_q(upd_flag)
    );

    // One register set per channel; the reload path exists only on AL_DST.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_hit, drop, ld_a, ld_c;
        // Write decode with autoload duplication and collision drop.
        always_comb begin
            wr_hit = wr_en && ((wr_ch == CH_W'(i)) ||
                     (autoload && (i == AL_SRC) && (wr_ch == CH_W'(AL_DST))));
            drop   = (i == AL_SRC) && reload;
            ld_a   = wr_hit && (wr_sel == SEL_ADDR) && !drop;
            ld_c   = wr_hit && (wr_sel == SEL_CNT) && !drop;
        end
        dma_al_chreg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_reg (
            .clk(clk), .rst_n(rst_n), .ld_addr(ld_a), .ld_cnt(ld_c),
            .ld_data(wr_data), .adv(adv[i]),
            .reload((i == AL_DST) ? reload : 1'b0),
            .rl_addr(addr_a[AL_SRC]), .rl_cnt(cnt_a[AL_SRC]),
            .addr_q(addr_a[i]), .cnt_q(cnt_a[i])
        );
    end

    AST_AL_DUP_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (autoload && wr_en && wr_ch == CH_W'(AL_DST) && wr_sel == SEL_ADDR && !reload)
        |=> (addr_a[AL_SRC] == $past(wr_data))); // R6
    AST_UPD_BEATS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && autoload) |=> (addr_a[AL_SRC] == $past(addr_a[AL_SRC]))); // R9
endmodule

// File: tb/sim_dma_al_core.sv
`timescale 1ns/100ps
module sim_dma_al_core;
    localparam int AW = 16, CW = 6;
    localparam logic [CW-1:0] WRAP = '1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, wr_sel = 0, en_wr = 0, tc_stop = 0, autoload = 0, xfer_done = 0;
    logic [1:0] wr_ch = 0, xfer_ch = 0;
    logic [AW-1:0] wr_data = 0;
    logic [3:0] en_wdata = 0;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_cnt;
    logic tc, upd_flag;
    logic [3:0] ch_en;
    int n_run = 0, n_fail = 0;
    logic tc_seen;

    always #2 clk = ~clk;

    dma_al_core #(.NUM_CH(4), .ADDR_W(AW), .CNT_W(CW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one clock of stimulus; tc_seen holds tc sampled before the edge.
    task automatic step(input logic wr, input logic [1:0] wch, input logic sel, input logic [AW-1:0] d,
                        input logic xd, input logic [1:0] xch);
        @(negedge clk);
        wr_en = wr; wr_ch = wch; wr_sel = sel; wr_data = d; xfer_done = xd; xfer_ch = xch;
        #0.5 tc_seen = tc;
        @(posedge clk); #0.5;
        wr_en = 0; xfer_done = 0;
    endtask

    task automatic wreg(input logic [1:0] ch, input logic sel, input logic [AW-1:0] d);
        step(1, ch, sel, d, 0, 0);
    endtask

    task automatic xfer(input logic [1:0] ch);
        step(0, 0, 0, 0, 1, ch);
    endtask

    task automatic set_en(input logic [3:0] e);
        @(negedge clk); en_wr = 1; en_wdata = e;
        @(posedge clk); #0.5; en_wr = 0;
    endtask

    task automatic peek(input logic [1:0] ch, output logic [AW-1:0] a, output logic [CW-1:0] c);
        xfer_ch = ch; #0.5; a = cur_addr; c = cur_cnt;
    endtask

    task automatic t_reset();
        logic [AW-1:0] a; logic [CW-1:0] c;
        for (int i = 0; i < 4; i++) begin
            peek(2'(i), a, c);
            chk("R10 addr", a, 0); chk("R10 cnt", c, 0);
        end
        chk("R10 en", ch_en, 0); chk("R10 upd", upd_flag, 0); chk("R10 tc", tc, 0);
    endtask

    task automatic t_advance_nostop();
        logic [AW-1:0] a; logic [CW-1:0] c;
        tc_stop = 0;
        wreg(1, 0, 16'h1000); wreg(1, 1, 16'd2); set_en(4'b0010);
        xfer(1); chk("R2 no tc mid-block", tc_seen, 0);
        peek(1, a, c); chk("R1 addr+1", a, 16'h1001); chk("R1 cnt-1", c, 1);
        xfer(0); peek(0, a, c); chk("R1 disabled addr", a, 0); chk("R1 disabled cnt", c, 0);
        xfer(1); chk("R2 no tc at 1", tc_seen, 0);
        xfer(1); chk("R2 tc at 0", tc_seen, 1);
        peek(1, a, c); chk("R2 wrap cnt", c, WRAP); chk("R2 addr", a, 16'h1003);
        chk("R4 enable kept", ch_en, 4'b0010);
    endtask

    task automatic t_stop();
        tc_stop = 1;
        wreg(0, 0, 16'h0005); wreg(0, 1, 16'd0); set_en(4'b0011);
        xfer(0); chk("R3 tc", tc_seen, 1);
        chk("R3 channel off", ch_en, 4'b0010);
    endtask

    task automatic t_repeat();
        logic [AW-1:0] a; logic [CW-1:0] c;
        autoload = 1; tc_stop = 1; set_en(4'b0100);
        wreg(2, 0, 16'h2000); wreg(2, 1, 16'd1);
        peek(3, a, c); chk("R6 dup addr", a, 16'h2000); chk("R6 dup cnt", c, 1);
        xfer(2); peek(2, a, c); chk("R5 ch2 runs without ch3 enable", a, 16'h2001);
        xfer(2); chk("R7 tc", tc_seen, 1);
        peek(2, a, c); chk("R7 reload addr", a, 16'h2000); chk("R7 reload cnt", c, 1);
        chk("R7 upd set", upd_flag, 1); chk("R5 ch2 kept enabled", ch_en[2], 1);
        xfer(2); chk("R8 upd cleared", upd_flag, 0);
        peek(2, a, c); chk("R8 addr", a, 16'h2001);
    endtask

    task automatic t_chain();
        logic [AW-1:0] a; logic [CW-1:0] c;
        set_en(4'b1100);
        wreg(2, 0, 16'h3000); wreg(2, 1, 16'd0);
        wreg(3, 0, 16'h4000); wreg(3, 1, 16'd1);
        xfer(3); peek(3, a, c); chk("R5 ch3 xfer ignored", a, 16'h4000);
        step(1, 3, 0, 16'h5000, 1, 2);
        chk("R9 tc", tc_seen, 1);
        peek(2, a, c); chk("R9 ch2 old ch3 addr", a, 16'h4000); chk("R7 chain cnt", c, 1);
        peek(3, a, c); chk("R9 ch3 write dropped", a, 16'h4000);
        autoload = 0;
    endtask

    task automatic t_wr_prec();
        logic [AW-1:0] a; logic [CW-1:0] c;
        set_en(4'b0010);
        wreg(1, 1, 16'd5);
        step(1, 1, 0, 16'h7777, 1, 1);
        peek(1, a, c); chk("R11 write wins", a, 16'h7777); chk("R11 count still advances", c, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1;
        t_reset();
        t_advance_nostop();
        t_stop();
        t_repeat();
        t_chain();
        t_wr_prec();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule